// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a host bus and a byte-wide flash array. The host reaches it with active-low chip enable, output enable and write enable, an address and an 8-bit data bus, all sampled on a system clock. A write strobe is taken as the cycle in which write enable returns high while chip enable is still low. The byte written at that point is decoded as a command.

Commands select what host reads return: raw array bytes, identifier codes or a status byte. A two-write sequence starts a block erase on an external erase engine through a one-cycle start pulse. The engine reports busy, done, suspended and four error flags. The status byte combines engine readiness, a suspend flag and sticky error bits. It is captured once at the start of each read and then held.

Command codes are 0xFF (array read), 0x90 (identifier read), 0x70 (status read), 0x50 (clear errors), 0x20 (erase setup) and 0xD0 (erase confirm). Status bit 7 means ready, bit 6 means suspended, bits 5, 4, 3 and 1 are sticky errors, and the other bits read zero.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is in array-read mode and `ready` is 1. In array mode `dout` equals `array_data`.
- R2: Command 0xFF is ignored while `eng_busy` is high and `eng_susp` is low. It is accepted while `eng_susp` is high.
- R3: In identifier mode, address 0 reads 0x89. Address 1 reads the device code for parameter DENSITY: 0 gives 0xA7, 1 gives 0xA6, 2 gives 0xAA.
- R4: In identifier mode, an address whose low two bits are 2 and whose middle bits (between bit 2 and the block field) are zero reads {7'b0, lock bit of the block in the top BLK_W address bits}. Address 3 reads {7'b0, master_lock}. Any other address reads 0x00.
- R5: The status byte is captured in the first cycle in which both `ce_n` and `oe_n` are low. It stays unchanged until a later read begins.
- R6: Engine error flags `eng_err[3:0]` are ORed into status bits 5, 4, 3 and 1, in that order, when `eng_done` is high. These bits accumulate across operations. Command 0x50 clears them and leaves the read mode unchanged.
- R7: Command 0x50 has no effect while `eng_susp` is high. Status bit 6 equals `eng_susp`.
- R8: Writing 0x20 and then 0xD0 pulses `eng_start` for one cycle. `eng_blk` then holds the block field of the confirm address. Only that block is erased.
- R9: After an erase confirm, reads return the status byte. Status bit 7 and `ready` stay 0 from the start pulse until the engine drops busy.
- R10: Commands 0x90, 0x70 and 0xFF select their read mode, and that mode persists across reads. An unknown command code changes nothing.
- R11: If an erase setup is followed by any byte other than 0xD0, status bits 5 and 4 are set, no start pulse occurs, and the controller switches to status mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a command is taken when it rises |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Command byte from the host |
| dout | output | 8 | Read data (array, identifier or latched status) |
| ready | output | 1 | 1 when the erase engine is idle |
| array_data | input | 8 | Array byte at `addr` |
| blk_lock | input | 2**BLK_W | Lock bit per block |
| master_lock | input | 1 | Global lock bit |
| eng_start | output | 1 | One-cycle erase start pulse |
| eng_blk | output | BLK_W | Block to erase |
| eng_busy | input | 1 | Engine running |
| eng_susp | input | 1 | Engine suspended |
| eng_done | input | 1 | One-cycle completion pulse |
| eng_err | input | 4 | Error flags reported with `eng_done` |

## Verification
The bench holds a status read open across the engine's completion. A design that refreshed the latch while output enable stayed low would report ready early. It sends 0xFF in the middle of an erase and expects status reads to continue; a decoder that obeyed the command would return array bytes. It also stacks a sequence error on top of an engine error, and attempts a clear while suspended. These expose error bits that overwrite rather than accumulate, and clears that ignore the suspend state. A malformed erase sequence must leave `ready` high and the array untouched; a design that started the engine anyway would erase a block.

// File: rtl/fci_pkg.sv
// Shared command codes, read-mode encoding and identifier constants
// for the flash command controller. Assumes an 8-bit command bus.
package fci_pkg;

    typedef enum logic [1:0] {
        M_ARRAY  = 2'd0,
        M_IDENT  = 2'd1,
        M_STATUS = 2'd2,
        M_SETUP  = 2'd3
    } mode_e;

    localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_RD_ID    = 8'h90;
    localparam logic [7:0] CMD_RD_STAT  = 8'h70;
    localparam logic [7:0] CMD_CLR_STAT = 8'h50;
    localparam logic [7:0] CMD_ERASE    = 8'h20;
    localparam logic [7:0] CMD_CONFIRM  = 8'hD0;

    localparam logic [7:0] MFR_CODE     = 8'h89;
    localparam logic [3:0] SEQ_ERR_BITS = 4'b1100;

    // Device code for the density variant (0 small, 1 medium, 2 large)
    function automatic logic [7:0] dev_code(input int density);
        case (density)
            0:       return 8'hA7;
            1:       return 8'hA6;
            default: return 8'hAA;
        endcase
    endfunction

endpackage

// File: rtl/fci_bus_sync.sv
// Host bus edge detector. Produces a write strobe in the cycle where
// we_n rises while ce_n is low, and a read-start pulse in the first cycle
// where ce_n and oe_n are both low. Assumes inputs are already synchronous.
module fci_bus_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic wr_stb,
    output logic rd_act,
    output logic rd_start
);

    logic we_q;
    logic rd_q;

    // Remember last write-enable level and last read-active level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q <= 1'b1;
            rd_q <= 1'b0;
        end else begin
            we_q <= we_n;
            rd_q <= rd_act;
        end
    end

    // Edge decode of the bus controls
    always_comb begin
        rd_act   = ~ce_n & ~oe_n & we_n;
        wr_stb   = ~we_q & we_n & ~ce_n;
        rd_start = rd_act & ~rd_q;
    end

endmodule

// File: rtl/fci_cmd_fsm.sv
// Command decoder and read-mode state machine. Decodes single-cycle
// commands and the two-write erase sequence, issues the engine start
// pulse, the sequence-error pulse and the clear pulse. Assumes wr_stb is
// a single-cycle strobe with cmd and blk_in valid in that cycle.
module fci_cmd_fsm
    import fci_pkg::*;
#(
    parameter int BLK_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [7:0]       cmd,
    input  logic [BLK_W-1:0] blk_in,
    input  logic             eng_busy,
    input  logic             eng_susp,
    output mode_e            mode,
    output logic             eng_start,
    output logic [BLK_W-1:0] eng_blk,
    output logic             seq_err,
    output logic             clr
);

    logic running;

    // Engine is actively working (or about to) and not suspended
    always_comb running = (eng_busy | eng_start) & ~eng_susp;

    // Mode register and one-cycle command pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= M_ARRAY;
            eng_start <= 1'b0;
            eng_blk   <= '0;
            seq_err   <= 1'b0;
            clr       <= 1'b0;
        end else begin
            eng_start <= 1'b0;
            seq_err   <= 1'b0;
            clr       <= 1'b0;
            if (wr_stb) begin
                if (mode == M_SETUP) begin
                    mode <= M_STATUS;
                    if (cmd == CMD_CONFIRM) begin
                        eng_start <= 1'b1;
                        eng_blk   <= blk_in;
                    end else begin
                        seq_err <= 1'b1;
                    end
                end else if (running) begin
                    if (cmd == CMD_RD_STAT) mode <= M_STATUS;
                end else begin
                    case (cmd)
                        CMD_RD_ARRAY: mode <= M_ARRAY;
                        CMD_RD_ID:    mode <= M_IDENT;
                        CMD_RD_STAT:  mode <= M_STATUS;
                        CMD_CLR_STAT: if (!eng_susp) clr <= 1'b1;
                        CMD_ERASE:    if (!eng_susp && !eng_busy) mode <= M_SETUP;
                        default:      ;
                    endcase
                end
            end
        end
    end

    AST_ARRAY_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && cmd == CMD_RD_ARRAY && eng_busy && !eng_susp) |=> mode == $past(mode)); // R2
    AST_START_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $past(mode) == M_SETUP); // R8
    AST_SEQERR_TO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> (mode == M_STATUS && !eng_start)); // R11
    AST_NO_CLEAR_SUSPENDED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !$past(eng_susp)); // R7

endmodule

// File: rtl/fci_status.sv
// Status byte builder. Keeps the sticky error bits, forms the live status
// byte and captures it into a read latch at each read start. Assumes clr
// is already blocked upstream while the engine is suspended.
module fci_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       eng_busy,
    input  logic       eng_start,
    input  logic       eng_susp,
    input  logic       eng_done,
    input  logic [3:0] eng_err,
    input  logic       seq_err,
    input  logic       clr,
    input  logic       rd_act,
    input  logic       rd_start,
    output logic [7:0] stat_live,
    output logic [7:0] stat_lat
);

    import fci_pkg::*;

    logic [3:0] sticky;   // {bit5, bit4, bit3, bit1}
    logic [3:0] sticky_nxt;

    // Next value of the sticky error bits
    always_comb begin
        sticky_nxt = clr ? 4'b0000 : sticky;
        if (eng_done) sticky_nxt = sticky_nxt | eng_err;
        if (seq_err)  sticky_nxt = sticky_nxt | SEQ_ERR_BITS;
    end

    // Assemble the live status byte
    always_comb begin
        stat_live = {~(eng_busy | eng_start), eng_susp, sticky[3], sticky[2],
                     sticky[1], 1'b0, sticky[0], 1'b0};
    end

    // Sticky register and read latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky   <= 4'b0000;
            stat_lat <= 8'h00;
        end else begin
            sticky <= sticky_nxt;
            if (rd_start) stat_lat <= stat_live;
        end
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((sticky & $past(sticky)) == $past(sticky))); // R6
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && $past(rd_act) && !$past(rd_start)) |-> $stable(stat_lat)); // R5

endmodule

// File: rtl/fci_id_read.sv
// Identifier readout. Decodes the address into manufacturer code, device
// code, per-block lock bit or master lock bit; unmatched addresses give 0.
// Assumes ADDR_W - BLK_W >= 3 so a middle address field exists.
module fci_id_read #(
    parameter int ADDR_W  = 8,
    parameter int BLK_W   = 2,
    parameter int DENSITY = 0
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [(1<<BLK_W)-1:0] blk_lock,
    input  logic                  master_lock,
    output logic [7:0]            id_byte
);

    import fci_pkg::*;

    localparam int MID_HI = ADDR_W - BLK_W - 1;

    logic [BLK_W-1:0] blk;
    logic             mid_zero;
    logic             top_zero;

    // Address field split
    always_comb begin
        blk      = addr[ADDR_W-1 -: BLK_W];
        mid_zero = (addr[MID_HI:2] == '0);
        top_zero = mid_zero && (blk == '0);
    end

    // Identifier byte selection
    always_comb begin
        id_byte = 8'h00;
        case (addr[1:0])
            2'd0: if (top_zero) id_byte = MFR_CODE;
            2'd1: if (top_zero) id_byte = dev_code(DENSITY);
            2'd2: if (mid_zero) id_byte = {7'b0, blk_lock[blk]};
            2'd3: if (top_zero) id_byte = {7'b0, master_lock};
            default: id_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
// Top of the flash command controller. Ties the bus edge detector, the
// command state machine, the status builder and the identifier readout
// together and selects the read data by mode. Assumes an external erase
// engine that raises busy the cycle after eng_start.
module flash_cmd_ctrl
    import fci_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int BLK_W   = 2,
    parameter int DENSITY = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ce_n,
    input  logic                  oe_n,
    input  logic                  we_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [7:0]            din,
    output logic [7:0]            dout,
    output logic                  ready,
    input  logic [7:0]            array_data,
    input  logic [(1<<BLK_W)-1:0] blk_lock,
    input  logic                  master_lock,
    output logic                  eng_start,
    output logic [BLK_W-1:0]      eng_blk,
    input  logic                  eng_busy,
    input  logic                  eng_susp,
    input  logic                  eng_done,
    input  logic [3:0]            eng_err
);

    logic       wr_stb;
    logic       rd_act;
    logic       rd_start;
    mode_e      mode;
    logic       seq_err;
    logic       clr;
    logic [7:0] stat_live;
    logic [7:0] stat_lat;
    logic [7:0] id_byte;

    fci_bus_sync u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .wr_stb   (wr_stb),
        .rd_act   (rd_act),
        .rd_start (rd_start)
    );

    fci_cmd_fsm #(.BLK_W(BLK_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .cmd       (din),
        .blk_in    (addr[ADDR_W-1 -: BLK_W]),
        .eng_busy  (eng_busy),
        .eng_susp  (eng_susp),
        .mode      (mode),
        .eng_start (eng_start),
        .eng_blk   (eng_blk),
        .seq_err   (seq_err),
        .clr       (clr)
    );

    fci_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .eng_busy  (eng_busy),
        .eng_start (eng_start),
        .eng_susp  (eng_susp),
        .eng_done  (eng_done),
        .eng_err   (eng_err),
        .seq_err   (seq_err),
        .clr       (clr),
        .rd_act    (rd_act),
        .rd_start  (rd_start),
        .stat_live (stat_live),
        .stat_lat  (stat_lat)
    );

    fci_id_read #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .DENSITY(DENSITY)) u_id (
        .addr        (addr),
        .blk_lock    (blk_lock),
        .master_lock (master_lock),
        .id_byte     (id_byte)
    );

    // Read data selection by current mode; ready mirrors status bit 7
    always_comb begin
        ready = stat_live[7];
        case (mode)
            M_ARRAY: dout = array_data;
            M_IDENT: dout = id_byte;
            default: dout = stat_lat;
        endcase
    end

    AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_IDENT && addr[1]) |-> dout[7:1] == 7'b0); // R4
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy || eng_start) |-> !ready); // R9

endmodule

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;

    localparam int ADDR_W = 8;
    localparam int BLK_W  = 2;
    localparam int LAT    = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        din = 8'h00;
    logic [7:0]        dout;
    logic              ready;
    logic [7:0]        array_data;
    logic [3:0]        blk_lock = 4'b0010;
    logic              master_lock = 1'b1;
    logic              eng_start;
    logic [BLK_W-1:0]  eng_blk;
    logic              eng_busy = 1'b0;
    logic              eng_susp = 1'b0;
    logic              eng_done = 1'b0;
    logic [3:0]        eng_err;
    logic [3:0]        err_inject = 4'b0000;

    logic [7:0] mem [256];
    int         cnt = 0;

    int         checks = 0;
    int         fails = 0;
    logic [7:0] q_exp [$];
    string      q_tag [$];
    logic [7:0] mon_val;
    event       mon_ev;

    always #2 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .DENSITY(0)) u_flash_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .ready(ready),
        .array_data(array_data), .blk_lock(blk_lock), .master_lock(master_lock),
        .eng_start(eng_start), .eng_blk(eng_blk), .eng_busy(eng_busy),
        .eng_susp(eng_susp), .eng_done(eng_done), .eng_err(eng_err)
    );

    assign array_data = mem[addr];
    assign eng_err    = err_inject;

    // Erase engine model: fixed latency, erases the chosen block on finish
    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (eng_start) begin
            eng_busy <= 1'b1;
            cnt      <= LAT;
        end else if (eng_busy) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                eng_busy <= 1'b0;
                eng_done <= 1'b1;
                for (int i = 0; i < 64; i++) mem[{eng_blk, i[5:0]}] <= 8'hFF;
            end
        end
    end

    // Scoreboard monitor: compare each sampled read with the queue head
    initial begin
        forever begin
            @(mon_ev);
            checks++;
            if (q_exp.size() == 0) begin
                fails++;
                $display("FAIL scoreboard empty: actual %02h expected none", mon_val);
            end else begin
                logic [7:0] e;
                string      t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                if (mon_val !== e) begin
                    fails++;
                    $display("FAIL %s: actual %02h expected %02h", t, mon_val, e);
                end
            end
        end
    end

    task automatic chk_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); ce_n = 1'b0; addr = a; din = d; we_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd_expect(input logic [7:0] a, input logic [7:0] e, input string tag);
        q_exp.push_back(e); q_tag.push_back(tag);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
        repeat (2) @(negedge clk);
        mon_val = dout; -> mon_ev;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    // Read held open for many cycles: value must not change
    task automatic rd_hold(input logic [7:0] e, input int hold, input string tag);
        q_exp.push_back(e); q_tag.push_back(tag);
        q_exp.push_back(e); q_tag.push_back(tag);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
        repeat (2) @(negedge clk);
        mon_val = dout; -> mon_ev;
        repeat (hold) @(negedge clk);
        mon_val = dout; -> mon_ev;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_ready();
        while (!ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = i[7:0];
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_bit(ready, 1'b1, "R1 ready after reset");
        rd_expect(8'h05, 8'h05, "R1 array read after reset");

        // R3 / R4 identifier readout
        bus_wr(8'h00, 8'h90);
        rd_expect(8'h00, 8'h89, "R3 manufacturer code");
        rd_expect(8'h01, 8'hA7, "R3 device code");
        rd_expect(8'h42, 8'h01, "R4 block1 locked");
        rd_expect(8'h82, 8'h00, "R4 block2 unlocked");
        rd_expect(8'h03, 8'h01, "R4 master lock");
        rd_expect(8'h05, 8'h00, "R4 unmatched address");
        rd_expect(8'h00, 8'h89, "R10 identifier mode persists");

        // R10 mode switching and unknown command
        bus_wr(8'h00, 8'hFF);
        rd_expect(8'h10, 8'h10, "R10 back to array");
        bus_wr(8'h00, 8'h12);
        rd_expect(8'h11, 8'h11, "R10 unknown command ignored");
        bus_wr(8'h00, 8'h70);
        rd_expect(8'h00, 8'h80, "R10 status mode idle");

        // R8 / R9 / R2 / R5 erase of block 1
        bus_wr(8'h00, 8'hFF);
        bus_wr(8'h40, 8'h20);
        bus_wr(8'h40, 8'hD0);
        chk_bit(ready, 1'b0, "R9 ready low while erasing");
        rd_expect(8'h00, 8'h00, "R9 auto status busy");
        bus_wr(8'h00, 8'hFF);
        rd_expect(8'h00, 8'h00, "R2 array command ignored while busy");
        rd_hold(8'h00, 60, "R5 latch held across completion");
        chk_bit(ready, 1'b1, "R9 ready after erase");
        rd_expect(8'h00, 8'h80, "R5 new read refreshes status");
        bus_wr(8'h00, 8'hFF);
        rd_expect(8'h40, 8'hFF, "R8 block start erased");
        rd_expect(8'h7F, 8'hFF, "R8 block end erased");
        rd_expect(8'h80, 8'h80, "R8 next block untouched");
        rd_expect(8'h3F, 8'h3F, "R8 previous block untouched");

        // R11 bad confirm
        bus_wr(8'h80, 8'h20);
        bus_wr(8'h80, 8'h33);
        chk_bit(ready, 1'b1, "R11 no engine start");
        rd_expect(8'h00, 8'hB0, "R11 sequence error bits");
        bus_wr(8'h00, 8'hFF);
        rd_expect(8'h80, 8'h80, "R11 array not erased");

        // R6 accumulation and clear
        err_inject = 4'b0010;
        bus_wr(8'hC0, 8'h20);
        bus_wr(8'hC0, 8'hD0);
        wait_ready();
        err_inject = 4'b0000;
        rd_expect(8'h00, 8'hB8, "R6 errors accumulate");
        bus_wr(8'h00, 8'h50);
        rd_expect(8'h00, 8'h80, "R6 clear keeps status mode");

        // R7 clear blocked while suspended, R2 array accepted when suspended
        bus_wr(8'h00, 8'h20);
        bus_wr(8'h00, 8'h00);
        eng_susp = 1'b1;
        bus_wr(8'h00, 8'h50);
        rd_expect(8'h00, 8'hF0, "R7 clear ignored in suspend");
        bus_wr(8'h00, 8'hFF);
        rd_expect(8'h05, 8'h05, "R2 array accepted while suspended");
        eng_susp = 1'b0;
        bus_wr(8'h00, 8'h50);
        bus_wr(8'h00, 8'h70);
        rd_expect(8'h00, 8'h80, "R7 clear after resume");

        repeat (4) @(negedge clk);
        checks++;
        if (q_exp.size() != 0) begin
            fails++;
            $display("FAIL scoreboard leftover: actual %0d expected 0", q_exp.size());
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule